// File: doc/BRIEF.md
# I2C Start and Data Timing Generator

This block measures out the short intervals an I2C bus engine must respect around START conditions and data transitions. It runs on the I2C kernel clock and holds four independent down-counters. Each counter is started by a one-cycle trigger from the bus engine and loaded from a programmed interval. When the interval has elapsed, the counter raises a one-cycle strobe that tells the engine it may act.

The four intervals are:
- the delay from issuing a START to driving SCL low;
- the delay from releasing SCL high to generating a repeated START;
- the delay from an SCL falling edge to changing SDA;
- the slave data setup delay after a clock stretch is released.

The two START intervals each have a standard-mode value and a fast-mode value, selected by a speed-mode input. The slave setup interval is one cycle shorter than its programmed value. Bit sequencing and SCL period generation belong to the bus engine, not to this block.

Top module: `bus_timing_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all four strobes are low.
- R2: A `start_issue_i` pulse raises `scl_low_ok_o` after N rising edges, counting the edge that samples the trigger as edge 1. N is `start_hold_std_i` when `fast_mode_i` is 0 and `start_hold_fst_i` when `fast_mode_i` is 1.
- R3: A `scl_released_i` pulse raises `start_gen_ok_o` after N edges. N is `start_setup_std_i` when `fast_mode_i` is 0 and `start_setup_fst_i` when `fast_mode_i` is 1.
- R4: A `scl_fall_i` pulse raises `sda_change_ok_o` after N edges, where N is `data_hold_i`.
- R5: A `stretch_release_i` pulse raises `slave_data_ok_o` after `slave_setup_i`−1 edges. A programmed value of 0, 1 or 2 gives a delay of one edge.
- R6: An effective interval of 0 or 1 raises the strobe right after the edge that samples the trigger (a delay of one edge).
- R7: A trigger that arrives while its counter is running restarts the full interval from that trigger. No strobe is produced for the abandoned count.
- R8: While `enable_i` is low, all counters are cleared, triggers are ignored, and no strobe is raised in the following cycle. A count interrupted by disabling never produces a strobe.
- R9: Each strobe is high for exactly one cycle, unless its trigger is asserted again.
- R10: The speed mode and the interval value are captured when the trigger is sampled. Changing them during a count has no effect on that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I2C kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Peripheral enable; low clears all counters |
| fast_mode_i | input | 1 | Speed mode: 0 standard, 1 fast |
| start_hold_std_i | input | 9 | START-to-SCL-low interval, standard mode |
| start_hold_fst_i | input | 9 | START-to-SCL-low interval, fast mode |
| start_setup_std_i | input | 9 | Repeated-START setup interval, standard mode |
| start_setup_fst_i | input | 9 | Repeated-START setup interval, fast mode |
| data_hold_i | input | 9 | SDA hold interval after an SCL fall |
| slave_setup_i | input | 16 | Slave data setup value (effective delay is value−1) |
| start_issue_i | input | 1 | Trigger: START issued |
| scl_released_i | input | 1 | Trigger: SCL released high before a repeated START |
| scl_fall_i | input | 1 | Trigger: SCL falling edge detected |
| stretch_release_i | input | 1 | Trigger: clock stretch released |
| scl_low_ok_o | output | 1 | Strobe: SCL may be driven low |
| start_gen_ok_o | output | 1 | Strobe: repeated START may be generated |
| sda_change_ok_o | output | 1 | Strobe: SDA may change |
| slave_data_ok_o | output | 1 | Strobe: slave data setup has elapsed |

## Verification
A corrupted remaining-count or active flag shows up at the ports as a strobe that comes early, comes late, is missing, or arrives with no trigger. This is visible at most one interval after the trigger, so every latency is measured edge by edge against the programmed value. A stale captured speed mode or value is caught by switching those inputs mid-count. A clear that fails on disable, or on restart, appears as a spurious strobe within the old interval.

// File: rtl/timing_gen_pkg.sv
package timing_gen_pkg;
  localparam int NUM_CH = 4;

  typedef enum logic [1:0] {
    CH_START_HOLD  = 2'd0,
    CH_START_SETUP = 2'd1,
    CH_DATA_HOLD   = 2'd2,
    CH_SLV_SETUP   = 2'd3
  } chan_e;

  function automatic int max_w(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tg_interval_sel.sv
module tg_interval_sel
  import timing_gen_pkg::*;
#(
  parameter int TW = 9,
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic                       fast_mode_i,
  input  logic [TW-1:0]              start_hold_std_i,
  input  logic [TW-1:0]              start_hold_fst_i,
  input  logic [TW-1:0]              start_setup_std_i,
  input  logic [TW-1:0]              start_setup_fst_i,
  input  logic [TW-1:0]              data_hold_i,
  input  logic [SW-1:0]              slave_setup_i,
  output logic [NUM_CH-1:0][CW-1:0]  delay_o
);
  logic [TW-1:0] hold_sel;
  logic [TW-1:0] setup_sel;
  logic [SW-1:0] slv_adj;

  always_comb begin
    hold_sel  = fast_mode_i ? start_hold_fst_i  : start_hold_std_i;
    setup_sel = fast_mode_i ? start_setup_fst_i : start_setup_std_i;
    // slave setup is one cycle shorter than programmed, saturating at zero
    slv_adj   = (slave_setup_i <= SW'(1)) ? '0 : slave_setup_i - SW'(1);
    delay_o[CH_START_HOLD]  = CW'(hold_sel);
    delay_o[CH_START_SETUP] = CW'(setup_sel);
    delay_o[CH_DATA_HOLD]   = CW'(data_hold_i);
    delay_o[CH_SLV_SETUP]   = CW'(slv_adj);
  end
endmodule

// File: rtl/tg_delay_chan.sv
module tg_delay_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          trig_i,
  input  logic [CW-1:0] delay_i,
  output logic          strobe_o
);
  logic [CW-1:0] remain_q;
  logic          active_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      remain_q <= '0;
      active_q <= 1'b0;
      strobe_o <= 1'b0;
    end else if (trig_i) begin
      // value captured here; 0 and 1 fire on the trigger edge itself
      if (delay_i <= CW'(1)) begin
        remain_q <= '0;
        active_q <= 1'b0;
        strobe_o <= 1'b1;
      end else begin
        remain_q <= delay_i - CW'(1);
        active_q <= 1'b1;
        strobe_o <= 1'b0;
      end
    end else if (active_q) begin
      if (remain_q == CW'(1)) begin
        remain_q <= '0;
        active_q <= 1'b0;
        strobe_o <= 1'b1;
      end else begin
        remain_q <= remain_q - CW'(1);
        strobe_o <= 1'b0;
      end
    end else begin
      strobe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_timing_gen.sv
module bus_timing_gen
  import timing_gen_pkg::*;
#(
  parameter int TW = 9,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable_i,
  input  logic          fast_mode_i,
  input  logic [TW-1:0] start_hold_std_i,
  input  logic [TW-1:0] start_hold_fst_i,
  input  logic [TW-1:0] start_setup_std_i,
  input  logic [TW-1:0] start_setup_fst_i,
  input  logic [TW-1:0] data_hold_i,
  input  logic [SW-1:0] slave_setup_i,
  input  logic          start_issue_i,
  input  logic          scl_released_i,
  input  logic          scl_fall_i,
  input  logic          stretch_release_i,
  output logic          scl_low_ok_o,
  output logic          start_gen_ok_o,
  output logic          sda_change_ok_o,
  output logic          slave_data_ok_o
);
  localparam int CW = max_w(TW, SW);

  logic [NUM_CH-1:0][CW-1:0] delay;
  logic [NUM_CH-1:0]         trig;
  logic [NUM_CH-1:0]         strobe;

  assign trig[CH_START_HOLD]  = start_issue_i;
  assign trig[CH_START_SETUP] = scl_released_i;
  assign trig[CH_DATA_HOLD]   = scl_fall_i;
  assign trig[CH_SLV_SETUP]   = stretch_release_i;

  tg_interval_sel #(.TW(TW), .SW(SW), .CW(CW)) u_sel (
    .fast_mode_i       (fast_mode_i),
    .start_hold_std_i  (start_hold_std_i),
    .start_hold_fst_i  (start_hold_fst_i),
    .start_setup_std_i (start_setup_std_i),
    .start_setup_fst_i (start_setup_fst_i),
    .data_hold_i       (data_hold_i),
    .slave_setup_i     (slave_setup_i),
    .delay_o           (delay)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    tg_delay_chan #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .en_i     (enable_i),
      .trig_i   (trig[g]),
      .delay_i  (delay[g]),
      .strobe_o (strobe[g])
    );
  end

  assign scl_low_ok_o    = strobe[CH_START_HOLD];
  assign start_gen_ok_o  = strobe[CH_START_SETUP];
  assign sda_change_ok_o = strobe[CH_DATA_HOLD];
  assign slave_data_ok_o = strobe[CH_SLV_SETUP];
endmodule

// File: rtl/bus_timing_chk.sv
module bus_timing_chk #(
  parameter int TW = 9,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          enable_i,
  input logic          fast_mode_i,
  input logic [TW-1:0] start_hold_std_i,
  input logic [TW-1:0] start_hold_fst_i,
  input logic [TW-1:0] data_hold_i,
  input logic [SW-1:0] slave_setup_i,
  input logic          start_issue_i,
  input logic          scl_released_i,
  input logic          scl_fall_i,
  input logic          stretch_release_i,
  input logic          scl_low_ok_o,
  input logic          start_gen_ok_o,
  input logic          sda_change_ok_o,
  input logic          slave_data_ok_o
);
  logic [3:0] trg;
  logic [3:0] stb;
  logic [TW-1:0] hold_now;

  assign trg = {stretch_release_i, scl_fall_i, scl_released_i, start_issue_i};
  assign stb = {slave_data_ok_o, sda_change_ok_o, start_gen_ok_o, scl_low_ok_o};
  assign hold_now = fast_mode_i ? start_hold_fst_i : start_hold_std_i;

  // R8: disabled cycle leaves every strobe low in the next cycle
  p_disable_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (stb == 4'b0));

  // R6 / R2: short START hold fires at once
  p_hold_short_r6: assert property (@(posedge clk) disable iff (rst)
    (enable_i && start_issue_i && hold_now <= TW'(1)) |=> scl_low_ok_o);

  // R2: longer START hold does not fire early
  p_hold_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (enable_i && start_issue_i && hold_now > TW'(1)) |=> !scl_low_ok_o);

  // R4 / R6: short data hold fires at once
  p_dhold_short_r4: assert property (@(posedge clk) disable iff (rst)
    (enable_i && scl_fall_i && data_hold_i <= TW'(1)) |=> sda_change_ok_o);

  // R5: slave setup of 2 or less gives a one-edge delay
  p_slv_short_r5: assert property (@(posedge clk) disable iff (rst)
    (enable_i && stretch_release_i && slave_setup_i <= SW'(2)) |=> slave_data_ok_o);

  // R5: slave setup of 3 waits two edges
  p_slv_three_r5: assert property (@(posedge clk) disable iff (rst)
    (enable_i && stretch_release_i && slave_setup_i == SW'(3)) |=> !slave_data_ok_o);

  // R9: strobes last one cycle unless retriggered
  for (genvar g = 0; g < 4; g++) begin : g_pulse
    p_single_r9: assert property (@(posedge clk) disable iff (rst)
      (stb[g] && !trg[g]) |=> !stb[g]);
  end
endmodule

bind bus_timing_gen bus_timing_chk #(.TW(TW), .SW(SW)) u_chk (
  .clk               (clk),
  .rst               (rst),
  .enable_i          (enable_i),
  .fast_mode_i       (fast_mode_i),
  .start_hold_std_i  (start_hold_std_i),
  .start_hold_fst_i  (start_hold_fst_i),
  .data_hold_i       (data_hold_i),
  .slave_setup_i     (slave_setup_i),
  .start_issue_i     (start_issue_i),
  .scl_released_i    (scl_released_i),
  .scl_fall_i        (scl_fall_i),
  .stretch_release_i (stretch_release_i),
  .scl_low_ok_o      (scl_low_ok_o),
  .start_gen_ok_o    (start_gen_ok_o),
  .sda_change_ok_o   (sda_change_ok_o),
  .slave_data_ok_o   (slave_data_ok_o)
);

// File: tb/tb_bus_timing_gen.sv
module tb_bus_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable_i = 1'b1;
  logic        fast_mode_i = 1'b0;
  logic [8:0]  hs_std = 9'd5, hs_fst = 9'd9, su_std = 9'd4, su_fst = 9'd7, dh = 9'd6;
  logic [15:0] slv = 16'd5;
  logic [3:0]  trig = 4'b0;
  logic [3:0]  strb;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_timing_gen dut (
    .clk(clk), .rst(rst), .enable_i(enable_i), .fast_mode_i(fast_mode_i),
    .start_hold_std_i(hs_std), .start_hold_fst_i(hs_fst),
    .start_setup_std_i(su_std), .start_setup_fst_i(su_fst),
    .data_hold_i(dh), .slave_setup_i(slv),
    .start_issue_i(trig[0]), .scl_released_i(trig[1]),
    .scl_fall_i(trig[2]), .stretch_release_i(trig[3]),
    .scl_low_ok_o(strb[0]), .start_gen_ok_o(strb[1]),
    .sda_change_ok_o(strb[2]), .slave_data_ok_o(strb[3])
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse trigger on channel ch, count edges until strobe, then confirm one-cycle pulse
  task automatic run_lat(input int ch, input int exp, input string req);
    int n = 0;
    bit seen = 1'b0;
    @(negedge clk); trig[ch] = 1'b1;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(posedge clk); n++;
      @(negedge clk); trig[ch] = 1'b0;
      if (strb[ch]) seen = 1'b1;
    end
    check(seen && n == exp, req, n, exp);
    @(negedge clk);
    check(strb[ch] == 1'b0, {req, " R9 pulse width"}, int'(strb[ch]), 0);
  endtask

  task automatic t_reset;
    check(strb == 4'b0, "R1 strobes in reset", int'(strb), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(strb == 4'b0, "R1 strobes after reset", int'(strb), 0);
  endtask

  task automatic t_start_hold;
    fast_mode_i = 1'b0; run_lat(0, 5, "R2 std hold");
    fast_mode_i = 1'b1; run_lat(0, 9, "R2 fast hold");
    fast_mode_i = 1'b0;
  endtask

  task automatic t_start_setup;
    fast_mode_i = 1'b0; run_lat(1, 4, "R3 std setup");
    fast_mode_i = 1'b1; run_lat(1, 7, "R3 fast setup");
    fast_mode_i = 1'b0;
  endtask

  task automatic t_data_hold;
    dh = 9'd6;   run_lat(2, 6, "R4 data hold 6");
    dh = 9'd300; run_lat(2, 300 > 40 ? 41 : 300, "R4 data hold long guard");
  endtask

  task automatic t_data_hold_long;
    int n = 0;
    bit seen = 1'b0;
    dh = 9'd45;
    @(negedge clk); trig[2] = 1'b1;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(posedge clk); n++;
      @(negedge clk); trig[2] = 1'b0;
      if (strb[2]) seen = 1'b1;
    end
    check(seen && n == 45, "R4 data hold 45", n, 45);
    dh = 9'd6;
  endtask

  task automatic t_short;
    dh = 9'd0; run_lat(2, 1, "R6 data hold 0");
    dh = 9'd1; run_lat(2, 1, "R6 data hold 1");
    hs_std = 9'd0; run_lat(0, 1, "R6 start hold 0");
    hs_std = 9'd5; dh = 9'd6;
  endtask

  task automatic t_slave;
    slv = 16'd5; run_lat(3, 4, "R5 slave setup 5");
    slv = 16'd3; run_lat(3, 2, "R5 slave setup 3");
    slv = 16'd2; run_lat(3, 1, "R5 slave setup 2");
    slv = 16'd0; run_lat(3, 1, "R5 slave setup 0");
    slv = 16'd5;
  endtask

  task automatic t_retrigger;
    bit early = 1'b0;
    dh = 9'd6;
    @(negedge clk); trig[2] = 1'b1;
    @(negedge clk); trig[2] = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); if (strb[2]) early = 1'b1;
    end
    check(!early, "R7 no strobe before restart", int'(early), 0);
    run_lat(2, 6, "R7 restarted interval");
  endtask

  task automatic t_capture;
    int n = 0;
    bit seen = 1'b0;
    fast_mode_i = 1'b0;
    @(negedge clk); trig[0] = 1'b1;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(posedge clk); n++;
      @(negedge clk); trig[0] = 1'b0; fast_mode_i = 1'b1; hs_std = 9'd20;
      if (strb[0]) seen = 1'b1;
    end
    check(seen && n == 5, "R10 captured at trigger", n, 5);
    fast_mode_i = 1'b0; hs_std = 9'd5;
  endtask

  task automatic t_disable;
    bit any = 1'b0;
    hs_std = 9'd8;
    @(negedge clk); trig[0] = 1'b1;
    @(negedge clk); trig[0] = 1'b0;
    @(negedge clk); enable_i = 1'b0;
    @(negedge clk); trig = 4'b1111;
    @(negedge clk); trig = 4'b0;
    check(strb == 4'b0, "R8 trigger ignored while disabled", int'(strb), 0);
    enable_i = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); if (strb != 4'b0) any = 1'b1;
    end
    check(!any, "R8 interrupted count cleared", int'(any), 0);
    hs_std = 9'd5;
    run_lat(0, 5, "R8 works after re-enable");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_start_hold();
    t_start_setup();
    dh = 9'd6; run_lat(2, 6, "R4 data hold 6");
    t_data_hold_long();
    t_short();
    t_slave();
    t_retrigger();
    t_capture();
    t_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule